// File: doc/BRIEF.md
# Tear-Free Wide Counter Register Window

This block holds a 32-bit free-running counter and exposes it through a 16-bit synchronous register bus with a small address window. The counter advances by one on every clock in which its count enable is high. Software sees the counter as two 16-bit words. Each access to those words still produces a coherent 32-bit value, even when the low word carries into the high word between two bus accesses.

Reads are coherent because of a snapshot. Reading the low word returns the live low 16 bits and, on the same edge, latches the live high 16 bits into a holding register. A later read of the high word returns that latched copy. Writes use the reverse order. Writing the high word only parks the data in a staging register. The next write to the low word then loads all 32 bits on one edge. A sticky wrap flag records that the low word rolled over from all-ones to zero. The flag is cleared by reading it.

Top module: `wide_ctr_bus`

## Requirements
- R1: After reset the counter, the holding register, the staging register, the wrap flag and `rdata` are all zero, so reads of addresses 0, 1 and 2 return 0x0000.
- R2: With `cnt_en` high and no load in the cycle, the counter increases by exactly one per clock. With `cnt_en` low it holds its value.
- R3: A read (`rd_en` high) is answered on `rdata` one clock later. `rdata` keeps its last value in cycles without `rd_en`.
- R4: A read of address 0 returns counter bits 15:0. On the same edge it copies bits 31:16 into the holding register. A read of address 1 returns the holding register, not the live upper word.
- R5: A write to address 1 only stores `wdata` in the staging register and leaves the counter unchanged.
- R6: A write to address 0 loads the whole counter on one edge, with bits 31:16 from the staging register and bits 15:0 from `wdata`.
- R7: A load in the same cycle as `cnt_en` wins: the counter takes exactly the loaded value, and no wrap is recorded for that cycle.
- R8: When an increment takes the low 16 bits from 0xFFFF to 0x0000, the wrap flag sets and stays set until it is read.
- R9: A read of address 2 returns the wrap flag in bit 0 (other bits zero) and clears the flag. If a new wrap occurs in that same cycle, the flag stays set.
- R10: Address 3 reads as 0x0000. Writes to addresses 2 and 3 change neither the counter, the staging register nor the flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Active-low synchronous reset |
| cnt_en | input | 1 | Count enable, one increment per clock while high |
| addr | input | 2 | Register address: 0 low word, 1 high word, 2 wrap flag, 3 reserved |
| wr_en | input | 1 | Write strobe for the current address |
| rd_en | input | 1 | Read strobe for the current address |
| wdata | input | 16 | Write data |
| rdata | output | 16 | Registered read data, valid the clock after `rd_en` |

## Verification
Two pairs of functions can meet in one clock. The first is a low-word load and a counter increment. The bench loads a value while `cnt_en` is high and the counter sits at 0xFFFF in its low word, then expects exactly the loaded value and a clear wrap flag. The second is a flag read and a fresh wrap. The bench reads address 2 on the same edge on which the low word rolls over. It expects the returned bit to be 1 and the flag still to read 1 once more, before a third read returns 0.

// File: rtl/wctr_pkg.sv
`timescale 1ns/1ps
package wctr_pkg;
    localparam int unsigned BUS_W_DEF = 16;
    localparam int unsigned ADDR_W    = 2;

    typedef enum logic [ADDR_W-1:0] {
        ADR_LO   = 2'd0,
        ADR_HI   = 2'd1,
        ADR_FLAG = 2'd2,
        ADR_RSV  = 2'd3
    } wctr_addr_e;
endpackage

// File: rtl/wctr_counter.sv
`timescale 1ns/1ps
module wctr_counter #(
    parameter int unsigned BUS_W  = wctr_pkg::BUS_W_DEF,
    parameter bit          OVF_EN = 1'b1
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               cnt_en,
    input  logic               load,
    input  logic [2*BUS_W-1:0] load_val,
    input  logic               flag_clr,
    output logic [2*BUS_W-1:0] cnt_q,
    output logic               ovf_q
);
    localparam int unsigned CNT_W = 2 * BUS_W;

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic             ovf;
    } ctr_state_t;

    ctr_state_t st_d, st_q;
    logic       low_full;
    logic       wrap_evt;

    assign low_full = &st_q.cnt[BUS_W-1:0];
    assign wrap_evt = cnt_en && !load && low_full;

    always_comb begin
        st_d = st_q;
        if (load) begin
            st_d.cnt = load_val;
        end else if (cnt_en) begin
            st_d.cnt = st_q.cnt + {{(CNT_W-1){1'b0}}, 1'b1};
        end
        if (wrap_evt) begin
            st_d.ovf = 1'b1;
        end else if (flag_clr) begin
            st_d.ovf = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign cnt_q = st_q.cnt;

    generate
        if (OVF_EN) begin : g_flag
            assign ovf_q = st_q.ovf;
        end else begin : g_noflag
            assign ovf_q = 1'b0;
        end
    endgenerate
endmodule

// File: rtl/wctr_regif.sv
`timescale 1ns/1ps
module wctr_regif
    import wctr_pkg::*;
#(
    parameter int unsigned BUS_W = wctr_pkg::BUS_W_DEF
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [ADDR_W-1:0]  addr,
    input  logic               wr_en,
    input  logic               rd_en,
    input  logic [BUS_W-1:0]   wdata,
    input  logic [2*BUS_W-1:0] cnt,
    input  logic               ovf,
    output logic               load,
    output logic [2*BUS_W-1:0] load_val,
    output logic               flag_clr,
    output logic [BUS_W-1:0]   hold_q,
    output logic [BUS_W-1:0]   stage_q,
    output logic [BUS_W-1:0]   rdata
);
    typedef struct packed {
        logic [BUS_W-1:0] hold;
        logic [BUS_W-1:0] stage;
        logic [BUS_W-1:0] rd;
    } rif_state_t;

    rif_state_t st_d, st_q;
    wctr_addr_e sel;

    assign sel = wctr_addr_e'(addr);

    always_comb begin
        st_d     = st_q;
        load     = 1'b0;
        flag_clr = 1'b0;
        load_val = {st_q.stage, wdata};
        if (wr_en) begin
            unique case (sel)
                ADR_LO:  load = 1'b1;
                ADR_HI:  st_d.stage = wdata;
                default: ;
            endcase
        end
        if (rd_en) begin
            unique case (sel)
                ADR_LO: begin
                    st_d.rd   = cnt[BUS_W-1:0];
                    st_d.hold = cnt[2*BUS_W-1:BUS_W];
                end
                ADR_HI:   st_d.rd = st_q.hold;
                ADR_FLAG: begin
                    st_d.rd  = {{(BUS_W-1){1'b0}}, ovf};
                    flag_clr = 1'b1;
                end
                default:  st_d.rd = '0;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign hold_q  = st_q.hold;
    assign stage_q = st_q.stage;
    assign rdata   = st_q.rd;
endmodule

// File: rtl/wide_ctr_bus.sv
`timescale 1ns/1ps
module wide_ctr_bus
    import wctr_pkg::*;
#(
    parameter int unsigned BUS_W  = wctr_pkg::BUS_W_DEF,
    parameter bit          OVF_EN = 1'b1
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 cnt_en,
    input  logic [ADDR_W-1:0]    addr,
    input  logic                 wr_en,
    input  logic                 rd_en,
    input  logic [BUS_W-1:0]     wdata,
    output logic [BUS_W-1:0]     rdata
);
    localparam int unsigned CNT_W = 2 * BUS_W;

    logic             load;
    logic [CNT_W-1:0] load_val;
    logic             flag_clr;
    logic [CNT_W-1:0] cnt_q;
    logic             ovf_q;
    logic [BUS_W-1:0] hold_q;
    logic [BUS_W-1:0] stage_q;

    wctr_counter #(.BUS_W(BUS_W), .OVF_EN(OVF_EN)) u_counter (
        .clk      (clk),
        .rst_n    (rst_n),
        .cnt_en   (cnt_en),
        .load     (load),
        .load_val (load_val),
        .flag_clr (flag_clr),
        .cnt_q    (cnt_q),
        .ovf_q    (ovf_q)
    );

    wctr_regif #(.BUS_W(BUS_W)) u_regif (
        .clk      (clk),
        .rst_n    (rst_n),
        .addr     (addr),
        .wr_en    (wr_en),
        .rd_en    (rd_en),
        .wdata    (wdata),
        .cnt      (cnt_q),
        .ovf      (ovf_q),
        .load     (load),
        .load_val (load_val),
        .flag_clr (flag_clr),
        .hold_q   (hold_q),
        .stage_q  (stage_q),
        .rdata    (rdata)
    );
endmodule

// File: rtl/wctr_chk.sv
`timescale 1ns/1ps
module wctr_chk #(
    parameter int unsigned BUS_W = 16
) (
    input logic               clk,
    input logic               rst_n,
    input logic               cnt_en,
    input logic [1:0]         addr,
    input logic               wr_en,
    input logic               rd_en,
    input logic [BUS_W-1:0]   wdata,
    input logic [BUS_W-1:0]   rdata,
    input logic [2*BUS_W-1:0] cnt_q,
    input logic [BUS_W-1:0]   hold_q,
    input logic [BUS_W-1:0]   stage_q,
    input logic               ovf_q
);
    logic ld_now;
    logic wrap_now;
    assign ld_now   = wr_en && (addr == 2'd0);
    assign wrap_now = cnt_en && !ld_now && (&cnt_q[BUS_W-1:0]);

    // R2
    count_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt_en && !ld_now) |=> cnt_q == $past(cnt_q) + 1);

    // R2
    count_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!cnt_en && !ld_now) |=> $stable(cnt_q));

    // R3
    rdata_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_en |=> $stable(rdata));

    // R4
    low_snap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && addr == 2'd0) |=> (hold_q == $past(cnt_q[2*BUS_W-1:BUS_W]))
                                    && (rdata == $past(cnt_q[BUS_W-1:0])));

    // R4
    high_from_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && addr == 2'd1) |=> rdata == $past(hold_q));

    // R5
    stage_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && addr == 2'd1) |=> stage_q == $past(wdata));

    // R6
    full_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ld_now |=> cnt_q == {$past(stage_q), $past(wdata)});

    // R8
    wrap_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wrap_now |=> ovf_q);

    // R9
    flag_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && addr == 2'd2 && !wrap_now) |=> !ovf_q);

    // R10
    rsv_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && addr == 2'd3) |=> rdata == '0);
endmodule

bind wide_ctr_bus wctr_chk #(.BUS_W(BUS_W)) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .cnt_en  (cnt_en),
    .addr    (addr),
    .wr_en   (wr_en),
    .rd_en   (rd_en),
    .wdata   (wdata),
    .rdata   (rdata),
    .cnt_q   (cnt_q),
    .hold_q  (hold_q),
    .stage_q (stage_q),
    .ovf_q   (ovf_q)
);

// File: tb/wide_ctr_bus_tb.sv
`timescale 1ns/1ps
module wide_ctr_bus_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cnt_en = 1'b0;
    logic [1:0]  addr = 2'd0;
    logic        wr_en = 1'b0;
    logic        rd_en = 1'b0;
    logic [15:0] wdata = 16'h0;
    logic [15:0] rdata;

    int checks = 0;
    int failures = 0;
    bit finished = 1'b0;

    always #2 clk = ~clk;

    wide_ctr_bus u_dut (
        .clk(clk), .rst_n(rst_n), .cnt_en(cnt_en), .addr(addr),
        .wr_en(wr_en), .rd_en(rd_en), .wdata(wdata), .rdata(rdata)
    );

    task automatic check(input string req, input logic [15:0] got, input logic [15:0] exp);
        checks++;
        if (got !== exp) begin
            failures++;
            $display("FAIL %s: got 0x%04h expected 0x%04h", req, got, exp);
        end
    endtask

    task automatic bus_rd(input logic [1:0] a, output logic [15:0] d);
        addr = a; rd_en = 1'b1;
        @(negedge clk);
        rd_en = 1'b0;
        d = rdata;
    endtask

    task automatic bus_wr(input logic [1:0] a, input logic [15:0] d);
        addr = a; wdata = d; wr_en = 1'b1;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic run(input int n);
        cnt_en = 1'b1;
        repeat (n) @(negedge clk);
        cnt_en = 1'b0;
    endtask

    task automatic load32(input logic [31:0] v);
        bus_wr(2'd1, v[31:16]);
        bus_wr(2'd0, v[15:0]);
    endtask

    task automatic t_reset;
        logic [15:0] d;
        bus_rd(2'd0, d); check("R1 low after reset", d, 16'h0000);
        bus_rd(2'd1, d); check("R1 high after reset", d, 16'h0000);
        bus_rd(2'd2, d); check("R1 flag after reset", d, 16'h0000);
    endtask

    task automatic t_count;
        logic [15:0] d;
        load32(32'h0000_0010);
        run(5);
        bus_rd(2'd0, d); check("R2 five increments", d, 16'h0015);
        repeat (4) @(negedge clk);
        bus_rd(2'd0, d); check("R2 hold while disabled", d, 16'h0015);
        check("R3 rdata kept idle pre", rdata, 16'h0015);
        repeat (3) @(negedge clk);
        check("R3 rdata kept idle", rdata, 16'h0015);
    endtask

    task automatic t_tear;
        logic [15:0] d;
        bus_rd(2'd2, d);
        load32(32'h0001_FFFF);
        bus_rd(2'd0, d); check("R4 low before carry", d, 16'hFFFF);
        run(1);
        bus_rd(2'd1, d); check("R4 high from snapshot", d, 16'h0001);
        bus_rd(2'd0, d); check("R4 low after carry", d, 16'h0000);
        bus_rd(2'd1, d); check("R4 high after new snapshot", d, 16'h0002);
        bus_rd(2'd2, d); check("R8 flag set by wrap", d, 16'h0001);
        bus_rd(2'd2, d); check("R9 flag cleared by read", d, 16'h0000);
    endtask

    task automatic t_write_order;
        logic [15:0] d;
        load32(32'h0000_4444);
        bus_wr(2'd1, 16'hABCD);
        bus_rd(2'd0, d); check("R5 low unchanged by high write", d, 16'h4444);
        bus_rd(2'd1, d); check("R5 high unchanged by high write", d, 16'h0000);
        bus_wr(2'd0, 16'h5678);
        bus_rd(2'd0, d); check("R6 low after full load", d, 16'h5678);
        bus_rd(2'd1, d); check("R6 high from staging", d, 16'hABCD);
    endtask

    task automatic t_priority;
        logic [15:0] d;
        bus_rd(2'd2, d);
        load32(32'h0000_FFFF);
        addr = 2'd0; wdata = 16'h1234; wr_en = 1'b1; cnt_en = 1'b1;
        @(negedge clk);
        wr_en = 1'b0; cnt_en = 1'b0;
        bus_rd(2'd0, d); check("R7 load beats increment", d, 16'h1234);
        bus_rd(2'd1, d); check("R7 high from staging", d, 16'h0000);
        bus_rd(2'd2, d); check("R7 no wrap on load", d, 16'h0000);
    endtask

    task automatic t_flag_race;
        logic [15:0] d;
        load32(32'h0000_FFFF);
        run(1);
        load32(32'h0000_FFFF);
        addr = 2'd2; rd_en = 1'b1; cnt_en = 1'b1;
        @(negedge clk);
        rd_en = 1'b0; cnt_en = 1'b0;
        d = rdata; check("R9 read during wrap returns 1", d, 16'h0001);
        bus_rd(2'd2, d); check("R9 set wins over clear", d, 16'h0001);
        bus_rd(2'd2, d); check("R8 sticky then cleared", d, 16'h0000);
    endtask

    task automatic t_reserved;
        logic [15:0] d;
        load32(32'h0007_0009);
        bus_wr(2'd2, 16'hFFFF);
        bus_rd(2'd2, d); check("R10 flag write ignored", d, 16'h0000);
        bus_wr(2'd3, 16'hFFFF);
        bus_rd(2'd3, d); check("R10 reserved reads zero", d, 16'h0000);
        bus_rd(2'd0, d); check("R10 low untouched", d, 16'h0009);
        bus_rd(2'd1, d); check("R10 high untouched", d, 16'h0007);
        bus_wr(2'd0, 16'h0001);
        bus_rd(2'd1, d); check("R10 staging untouched", d, 16'h0007);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_count();
        t_tear();
        t_write_order();
        t_priority();
        t_flag_race();
        t_reserved();
        if (!finished) begin
            finished = 1'b1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            finished = 1'b1;
            checks++;
            failures++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule